// File: doc/BRIEF.md
# Memory Protection Permission Checker

This block decides whether one memory access may proceed. The access arrives as a byte address, a size in bytes, a three-bit set of requested permissions (read, write, execute) and a two-bit privilege mode. The block compares the access with a small table of protection entries and returns a grant flag and the set of permissions the deciding rule allows. The table is not stored here. Each entry's inclusive lower and upper byte bounds and its configuration byte arrive as flat input vectors, so this block holds no configuration state.

Entries are scanned from index 0 upward. The first byte and the last byte of the access are each tested against an entry's bounds. An access with only one of those two bytes inside an entry is refused outright. An access with both bytes inside an enabled entry takes that entry's permissions. Machine mode ignores an entry's permission bits unless that entry is locked. When nothing decides the access, machine mode is allowed everything and lower modes are refused. A request is accepted on any cycle with `reqValid` high, and the answer is registered and appears one clock later.

Top module: `pmp_checker`

## Requirements
- R1: `respValid` is high exactly in the cycle after a cycle with `reqValid` high. `respGrant` and `respAllowed` keep their values while no new request arrives.
- R2: After reset, `respValid`, `respGrant` and `respAllowed` are all zero.
- R3: If every entry's mode field (cfg bits [4:3]) is zero, a machine-mode request (mode 3) is granted with allowed = 3'b111. A user-mode (0) or supervisor-mode (1) request is denied with allowed = 3'b000. Entry bounds are not consulted in this case.
- R4: Entries are checked from index 0 upward, and the lowest-index entry that decides the access sets the result.
- R5: Once at least one entry is enabled, an access is denied with allowed = 3'b000 when any entry holds exactly one of its first and last bytes, provided no lower-index entry has already decided the access. This applies even to a disabled entry.
- R6: An entry matches only when both the first and the last byte lie inside its inclusive bounds and its mode field is non-zero. A disabled entry that fully contains the access is skipped.
- R7: On a match, allowed equals the entry's cfg bits [2:0] (bit0 R, bit1 W, bit2 X) when the mode is not machine or the entry's lock bit (cfg bit 7) is set. Otherwise allowed is 3'b111.
- R8: On a match, the access is granted only when every requested bit in `reqPerm` (bit0 R, bit1 W, bit2 X) is also set in allowed.
- R9: When at least one entry is enabled and none matches or straddles, machine mode is granted with 3'b111 and the other modes are denied with 3'b000.
- R10: A request size of zero means XLEN/8 bytes, so the last byte is addr + XLEN/8 - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | ADDR_W | Byte address of the first byte |
| reqSize | input | SIZE_W | Access size in bytes, 0 means XLEN/8 |
| reqPerm | input | 3 | Requested permissions: bit0 R, bit1 W, bit2 X |
| reqMode | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| entryLo | input | NUM_ENTRIES*ADDR_W | Inclusive lower bound of entry i at [i*ADDR_W +: ADDR_W] |
| entryHi | input | NUM_ENTRIES*ADDR_W | Inclusive upper bound of entry i at [i*ADDR_W +: ADDR_W] |
| entryCfg | input | NUM_ENTRIES*8 | Cfg byte of entry i: [2:0] RWX, [4:3] mode (0 off), [7] lock |
| respValid | output | 1 | Response valid, one cycle after the request |
| respGrant | output | 1 | Access granted |
| respAllowed | output | 3 | Permissions allowed by the deciding rule |

## Verification
The table is loaded with two nested windows of different strength, a disabled window and a locked window above it. Each access is placed so that the result shows which entry decided it. Reads, writes and executes in user, supervisor and machine mode separate the path that masks permissions from the machine-mode bypass, and separate the locked case from the unlocked one. Accesses that run off the end of a window, including one against a disabled entry, separate straddle denial from fall-through. Zero-size accesses placed one byte apart show whether the XLEN/8 default is applied. With every entry disabled, a straddling machine access shows that the no-entry case skips the scan.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;
  localparam int CFG_W      = 8;
  localparam int CFG_LOCK   = 7;
  localparam int CFG_MODE_L = 3;
  localparam logic [1:0] PRIV_MACHINE = 2'b11;
  localparam logic [2:0] PERM_ALL     = 3'b111;

  typedef struct packed {
    logic       capture;
    logic       grant;
    logic [2:0] allowed;
  } pmpStrobe_t;
endpackage

// File: rtl/pmp_chk_datapath.sv
module pmp_chk_datapath
  import pmp_chk_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 8,
  parameter int XLEN        = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [SIZE_W-1:0]             reqSize,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] entryLo,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] entryHi,
  input  pmpStrobe_t                    strobe,
  output logic [NUM_ENTRIES-1:0]        firstIn,
  output logic [NUM_ENTRIES-1:0]        lastIn,
  output logic                          respValid,
  output logic                          respGrant,
  output logic [2:0]                    respAllowed
);
  localparam logic [ADDR_W-1:0] DEFAULT_BYTES = ADDR_W'(XLEN / 8);

  logic [ADDR_W-1:0] effBytes;
  logic [ADDR_W-1:0] lastAddr;

  assign effBytes = (reqSize == '0) ? DEFAULT_BYTES : ADDR_W'(reqSize);
  assign lastAddr = reqAddr + effBytes - ADDR_W'(1);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
    logic [ADDR_W-1:0] lo, hi;
    assign lo = entryLo[i*ADDR_W +: ADDR_W];
    assign hi = entryHi[i*ADDR_W +: ADDR_W];
    assign firstIn[i] = (reqAddr >= lo) && (reqAddr <= hi);
    assign lastIn[i]  = (lastAddr >= lo) && (lastAddr <= hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respValid   <= 1'b0;
      respGrant   <= 1'b0;
      respAllowed <= 3'b000;
    end else begin
      respValid <= strobe.capture;
      if (strobe.capture) begin
        respGrant   <= strobe.grant;
        respAllowed <= strobe.allowed;
      end
    end
  end
endmodule

// File: rtl/pmp_chk_control.sv
module pmp_chk_control
  import pmp_chk_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input  logic                         reqValid,
  input  logic [2:0]                   reqPerm,
  input  logic [1:0]                   reqMode,
  input  logic [NUM_ENTRIES*CFG_W-1:0] entryCfg,
  input  logic [NUM_ENTRIES-1:0]       firstIn,
  input  logic [NUM_ENTRIES-1:0]       lastIn,
  output pmpStrobe_t                   strobe
);
  logic [NUM_ENTRIES-1:0] enabled;
  logic [NUM_ENTRIES-1:0] locked;
  logic [2:0]             rwx [NUM_ENTRIES];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cfg
    assign enabled[i] = |entryCfg[i*CFG_W + CFG_MODE_L +: 2];
    assign locked[i]  = entryCfg[i*CFG_W + CFG_LOCK];
    assign rwx[i]     = entryCfg[i*CFG_W +: 3];
  end

  logic       isMachine;
  logic       decided;
  logic       grantNext;
  logic [2:0] allowNext;

  assign isMachine = (reqMode == PRIV_MACHINE);

  always_comb begin
    decided   = 1'b0;
    grantNext = isMachine;
    allowNext = isMachine ? PERM_ALL : 3'b000;
    if (|enabled) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (!decided) begin
          if (firstIn[i] ^ lastIn[i]) begin
            decided   = 1'b1;
            grantNext = 1'b0;
            allowNext = 3'b000;
          end else if (firstIn[i] && lastIn[i] && enabled[i]) begin
            decided   = 1'b1;
            allowNext = (!isMachine || locked[i]) ? rwx[i] : PERM_ALL;
            grantNext = ((reqPerm & allowNext) == reqPerm);
          end
        end
      end
    end
    strobe.capture = reqValid;
    strobe.grant   = grantNext;
    strobe.allowed = allowNext;
  end
endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_chk_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 8,
  parameter int XLEN        = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reqValid,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [SIZE_W-1:0]             reqSize,
  input  logic [2:0]                    reqPerm,
  input  logic [1:0]                    reqMode,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] entryLo,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] entryHi,
  input  logic [NUM_ENTRIES*CFG_W-1:0]  entryCfg,
  output logic                          respValid,
  output logic                          respGrant,
  output logic [2:0]                    respAllowed
);
  pmpStrobe_t             strobe;
  logic [NUM_ENTRIES-1:0] firstIn;
  logic [NUM_ENTRIES-1:0] lastIn;

  pmp_chk_control #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .reqValid (reqValid),
    .reqPerm  (reqPerm),
    .reqMode  (reqMode),
    .entryCfg (entryCfg),
    .firstIn  (firstIn),
    .lastIn   (lastIn),
    .strobe   (strobe)
  );

  pmp_chk_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .XLEN(XLEN)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqAddr     (reqAddr),
    .reqSize     (reqSize),
    .entryLo     (entryLo),
    .entryHi     (entryHi),
    .strobe      (strobe),
    .firstIn     (firstIn),
    .lastIn      (lastIn),
    .respValid   (respValid),
    .respGrant   (respGrant),
    .respAllowed (respAllowed)
  );
endmodule

// File: rtl/pmp_checker_props.sv
module pmp_checker_props
  import pmp_chk_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         reqValid,
  input logic [2:0]                   reqPerm,
  input logic [1:0]                   reqMode,
  input logic [NUM_ENTRIES*CFG_W-1:0] entryCfg,
  input logic                         respValid,
  input logic                         respGrant,
  input logic [2:0]                   respAllowed
);
  logic [NUM_ENTRIES-1:0] modeOn;
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_on
    assign modeOn[i] = entryCfg[i*CFG_W + CFG_MODE_L] | entryCfg[i*CFG_W + CFG_MODE_L + 1];
  end
  logic noneOn;
  assign noneOn = (modeOn == '0);

  assert_resp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> respValid);
  assert_no_spurious_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !respValid);
  assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> ($stable(respGrant) && $stable(respAllowed)));
  assert_grant_covers_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> (!respGrant || ((respAllowed & $past(reqPerm)) == $past(reqPerm))));
  assert_empty_machine_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && noneOn && reqMode == PRIV_MACHINE) |=> (respGrant && respAllowed == PERM_ALL));
  assert_empty_lower_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && noneOn && reqMode != PRIV_MACHINE) |=> (!respGrant && respAllowed == 3'b000));
endmodule

bind pmp_checker pmp_checker_props #(.NUM_ENTRIES(NUM_ENTRIES)) u_props (
  .clk         (clk),
  .rst_n       (rst_n),
  .reqValid    (reqValid),
  .reqPerm     (reqPerm),
  .reqMode     (reqMode),
  .entryCfg    (entryCfg),
  .respValid   (respValid),
  .respGrant   (respGrant),
  .respAllowed (respAllowed)
);

// File: tb/pmp_checker_test.sv
module pmp_checker_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int SW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reqValid = 1'b0;
  logic [AW-1:0]   reqAddr = '0;
  logic [SW-1:0]   reqSize = '0;
  logic [2:0]      reqPerm = '0;
  logic [1:0]      reqMode = '0;
  logic [N*AW-1:0] entryLo = '0;
  logic [N*AW-1:0] entryHi = '0;
  logic [N*8-1:0]  entryCfg = '0;
  logic            respValid;
  logic            respGrant;
  logic [2:0]      respAllowed;

  int testsRun = 0;
  int testsFailed = 0;
  logic [3:0] expQ[$];
  string      tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pmp_checker #(.NUM_ENTRIES(N), .ADDR_W(AW), .SIZE_W(SW), .XLEN(32)) uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqPerm(reqPerm), .reqMode(reqMode),
    .entryLo(entryLo), .entryHi(entryHi), .entryCfg(entryCfg),
    .respValid(respValid), .respGrant(respGrant), .respAllowed(respAllowed)
  );

  task automatic setEntry(input int idx, input logic [AW-1:0] lo,
                          input logic [AW-1:0] hi, input logic [7:0] cfg);
    entryLo[idx*AW +: AW] = lo;
    entryHi[idx*AW +: AW] = hi;
    entryCfg[idx*8 +: 8]  = cfg;
  endtask

  // driver: issue one request and queue its expected response
  task automatic issue(input logic [AW-1:0] addr, input logic [SW-1:0] size,
                       input logic [2:0] perm, input logic [1:0] mode,
                       input logic expGrant, input logic [2:0] expAllow,
                       input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqSize = size;
    reqPerm = perm; reqMode = mode;
    expQ.push_back({expGrant, expAllow});
    tagQ.push_back(tag);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor: compare each response with the queue head
  always @(posedge clk) begin
    #2;
    if (rst_n && respValid) begin
      logic [3:0] exp;
      string tag;
      testsRun++;
      if (expQ.size() == 0) begin
        testsFailed++;
        $display("FAIL R1 unexpected response got=%b%03b expected none", respGrant, respAllowed);
      end else begin
        exp = expQ.pop_front();
        tag = tagQ.pop_front();
        if ({respGrant, respAllowed} !== exp) begin
          testsFailed++;
          $display("FAIL %s grant/allowed got=%b/%03b expected=%b/%03b",
                   tag, respGrant, respAllowed, exp[3], exp[2:0]);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    testsFailed++;
    $display("FAIL R1 watchdog expired got=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    // R2 reset state
    repeat (2) @(negedge clk);
    testsRun++;
    if ({respValid, respGrant, respAllowed} !== 5'b0) begin
      testsFailed++;
      $display("FAIL R2 reset got=%b%b%03b expected=00000", respValid, respGrant, respAllowed);
    end
    rst_n = 1'b1;

    // R3 no enabled entries: straddling bounds ignored
    setEntry(0, 32'h100, 32'h1FF, 8'h07);
    issue(32'h1FE, 8'd4, 3'b001, 2'd3, 1'b1, 3'b111, "R3 machine, no entries");
    issue(32'h1FE, 8'd4, 3'b001, 2'd0, 1'b0, 3'b000, "R3 user, no entries");

    // table: e0 narrow R, e1 wide RWX, e2 disabled, e3 locked R|X
    setEntry(0, 32'h1000, 32'h10FF, 8'h09);
    setEntry(1, 32'h1000, 32'h1FFF, 8'h0F);
    setEntry(2, 32'h3000, 32'h30FF, 8'h07);
    setEntry(3, 32'h3000, 32'h3FFF, 8'h8D);

    issue(32'h1010, 8'd4, 3'b001, 2'd0, 1'b1, 3'b001, "R4 lowest entry read");
    issue(32'h1010, 8'd4, 3'b010, 2'd0, 1'b0, 3'b001, "R8 write missing");
    issue(32'h1800, 8'd4, 3'b010, 2'd0, 1'b1, 3'b111, "R4 falls to entry1");
    issue(32'h10FE, 8'd4, 3'b001, 2'd0, 1'b0, 3'b000, "R5 straddle entry0");
    issue(32'h1010, 8'd4, 3'b010, 2'd3, 1'b1, 3'b111, "R7 machine unlocked bypass");
    issue(32'h3010, 8'd4, 3'b001, 2'd0, 1'b1, 3'b101, "R6 disabled entry skipped");
    issue(32'h3010, 8'd4, 3'b010, 2'd3, 1'b0, 3'b101, "R7 machine locked masked");
    issue(32'h3010, 8'd4, 3'b100, 2'd1, 1'b1, 3'b101, "R7 supervisor exec");
    issue(32'h5000, 8'd4, 3'b001, 2'd0, 1'b0, 3'b000, "R9 user no match");
    issue(32'h5000, 8'd4, 3'b001, 2'd3, 1'b1, 3'b111, "R9 machine no match");
    issue(32'h10FC, 8'd0, 3'b001, 2'd0, 1'b1, 3'b001, "R10 size0 fits");
    issue(32'h10FD, 8'd0, 3'b001, 2'd0, 1'b0, 3'b000, "R10 size0 straddles");
    issue(32'h30FE, 8'd4, 3'b001, 2'd0, 1'b0, 3'b000, "R5 straddle disabled entry");
    issue(32'h1800, 8'd1, 3'b111, 2'd1, 1'b1, 3'b111, "R8 all perms granted");

    // R1: idle cycles produce no response and outputs hold
    repeat (3) @(negedge clk);
    testsRun++;
    if ({respValid, respGrant, respAllowed} !== 5'b01111) begin
      testsFailed++;
      $display("FAIL R1 idle hold got=%b%b%03b expected=01111", respValid, respGrant, respAllowed);
    end
    testsRun++;
    if (expQ.size() != 0) begin
      testsFailed++;
      $display("FAIL R1 missing responses got=%0d expected=0", expQ.size());
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule